// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block collects interrupt requests for one processor core and decides which one to present next. Each request carries an 8-bit vector, a 3-bit delivery mode and a level/edge trigger flag. Ordinary requests (fixed and lowest-priority modes) are queued as bits in a 256-entry request array, with a matching trigger-mode array. When one is taken it moves into a 256-entry in-service array. System-management, non-maskable, init and external requests each use a single pending slot that also stores the vector.

Every cycle the block compares the pending sources and drives a pending flag, a vector, a type code and the trigger bit of the chosen vector. When the core acknowledges, the block takes the presented interrupt out of its pending state. An end-of-interrupt pulse retires the highest vector that is in service. The core supplies the task priority and its interrupt-enable flag as plain inputs.

Top module: `irq_arbiter`

## Requirements
- R1: A request in mode 0 (fixed) or 1 (lowest-priority) sets the vector's request bit if that bit is clear. At the same time it writes the vector's trigger bit from `req_level`. A repeated request for a vector whose request bit is already set changes neither bit.
- R2: A request in mode 2 (system-management), 4 (non-maskable), 5 (init) or 7 (external) sets that class's pending slot and captures the vector. While the slot is already pending, a new request of that class is ignored.
- R3: Requests in mode 3 or 6 are dropped without any effect.
- R4: Types 1, 2 and 3 are presented whatever the level of `int_enable`.
- R5: External (type 4) and regular (type 5) interrupts are presented only while `int_enable` is high.
- R6: A regular interrupt is presented only when the highest requested vector meets two conditions. Its upper nibble must be strictly greater than the upper nibble of `task_prio`. It must also be strictly greater than the highest in-service vector, if any vector is in service.
- R7: Selection priority runs type 1, then 2, then 3, then 4, then 5. `irq_type` is 0 when nothing is pending. `irq_level` shows the trigger bit of a presented regular vector and is 0 for the other types.
- R8: Acknowledging a regular interrupt clears its request bit and sets its in-service bit.
- R9: Acknowledging type 1 to 4 clears only that one pending slot. An acknowledge while `irq_pending` is low has no effect.
- R10: An `eoi` pulse clears the highest set in-service bit. Any lower in-service vector then becomes the reference for R6.
- R11: A request and an acknowledge in the same cycle both take effect. The acknowledge acts on the state from before the request.
- R12: After reset nothing is pending: `irq_pending`=0, `irq_type`=0, `irq_vector`=0, `irq_level`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_vector | input | 8 | Vector of the request |
| req_mode | input | 3 | Delivery mode of the request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| task_prio | input | 8 | Task priority; its upper nibble gates regular vectors |
| int_enable | input | 1 | Core interrupt-enable flag |
| ack | input | 1 | Core takes the presented interrupt |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| irq_pending | output | 1 | An interrupt is being presented |
| irq_vector | output | 8 | Vector of the presented interrupt |
| irq_type | output | 3 | 0 none, 1 sys-mgmt, 2 non-maskable, 3 init, 4 external, 5 regular |
| irq_level | output | 1 | Trigger bit of the presented regular vector |

## Verification
The hardest case to reach is the in-service gate of R6, because the in-service array changes only through acknowledges and end-of-interrupt pulses. The stimulus acknowledges one vector and then another, higher one, so that two vectors are in service at once. It then holds a lower request that each `eoi` pulse in turn either blocks or releases. A second hard case is the same-cycle overlap of R11. The bench raises `ack` and `req_valid` on the same edge, with the request aimed at a higher vector or at the class that is being acknowledged.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int VEC_W = 8;
  localparam int NUM_VEC = 1 << VEC_W;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMGMT  = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMASK  = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV6   = 3'd6,
    DM_EXTERN = 3'd7
  } dmode_e;

  typedef enum logic [2:0] {
    IT_NONE   = 3'd0,
    IT_SMGMT  = 3'd1,
    IT_NMASK  = 3'd2,
    IT_INIT   = 3'd3,
    IT_EXTERN = 3'd4,
    IT_REG    = 3'd5
  } itype_e;

  localparam int NUM_SLOT = 4;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int WIDTH = 256,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             valid
);
  always_comb begin
    idx   = '0;
    valid = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) begin
        idx   = IDX_W'(i);
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pend_slot.sv
module irq_pend_slot #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr,
  input  logic [VW-1:0] vec_in,
  output logic          pend,
  output logic [VW-1:0] vec
);
  logic          pend_d;
  logic [VW-1:0] vec_d;
  logic          capture;

  assign capture = set && !pend;

  always_comb begin
    pend_d = pend ? !clr : set;
    vec_d  = capture ? vec_in : vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      vec  <= '0;
    end else begin
      pend <= pend_d;
      if (capture) vec <= vec_d;
    end
  end

  AST_SLOT_HOLDS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> (pend && $stable(vec))); // R2
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int CLS_W = 4,
  localparam int NV = 1 << VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vector,
  input  logic [2:0]    req_mode,
  input  logic          req_level,
  input  logic [VW-1:0] task_prio,
  input  logic          int_enable,
  input  logic          ack,
  input  logic          eoi,
  output logic          irq_pending,
  output logic [VW-1:0] irq_vector,
  output logic [2:0]    irq_type,
  output logic          irq_level
);
  logic [NV-1:0] irr_q, irr_d, isr_q, isr_d, tmr_q, tmr_d;
  logic [VW-1:0] irr_top, isr_top;
  logic          irr_any, isr_any;
  logic          reg_ok, state_en, ack_take;
  logic [NUM_SLOT-1:0] slot_set, slot_clr, slot_pend;
  logic [VW-1:0] slot_vec [NUM_SLOT];
  logic          req_regular;
  itype_e        sel_type;

  irq_prio_enc #(.WIDTH(NV)) u_irr_enc (.vec(irr_q), .idx(irr_top), .valid(irr_any));
  irq_prio_enc #(.WIDTH(NV)) u_isr_enc (.vec(isr_q), .idx(isr_top), .valid(isr_any));

  assign req_regular = req_valid &&
                       (dmode_e'(req_mode) == DM_FIXED || dmode_e'(req_mode) == DM_LOWEST);

  // slot index: 0 sys-mgmt, 1 non-maskable, 2 init, 3 external
  always_comb begin
    slot_set = '0;
    if (req_valid) begin
      case (dmode_e'(req_mode))
        DM_SMGMT:  slot_set[0] = 1'b1;
        DM_NMASK:  slot_set[1] = 1'b1;
        DM_INIT:   slot_set[2] = 1'b1;
        DM_EXTERN: slot_set[3] = 1'b1;
        default:   slot_set = '0;
      endcase
    end
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    irq_pend_slot #(.VW(VW)) u_slot (
      .clk(clk), .rst_n(rst_n), .set(slot_set[s]), .clr(slot_clr[s]),
      .vec_in(req_vector), .pend(slot_pend[s]), .vec(slot_vec[s]));
  end

  assign reg_ok = irr_any && (!isr_any || irr_top > isr_top) &&
                  (irr_top[VW-1 -: CLS_W] > task_prio[VW-1 -: CLS_W]);

  always_comb begin
    sel_type   = IT_NONE;
    irq_vector = '0;
    irq_level  = 1'b0;
    if (slot_pend[0]) begin
      sel_type = IT_SMGMT;  irq_vector = slot_vec[0];
    end else if (slot_pend[1]) begin
      sel_type = IT_NMASK;  irq_vector = slot_vec[1];
    end else if (slot_pend[2]) begin
      sel_type = IT_INIT;   irq_vector = slot_vec[2];
    end else if (int_enable && slot_pend[3]) begin
      sel_type = IT_EXTERN; irq_vector = slot_vec[3];
    end else if (int_enable && reg_ok) begin
      sel_type = IT_REG;    irq_vector = irr_top; irq_level = tmr_q[irr_top];
    end
  end

  assign irq_type    = sel_type;
  assign irq_pending = (sel_type != IT_NONE);
  assign ack_take    = ack && irq_pending;

  always_comb begin
    slot_clr = '0;
    case (sel_type)
      IT_SMGMT:  slot_clr[0] = ack_take;
      IT_NMASK:  slot_clr[1] = ack_take;
      IT_INIT:   slot_clr[2] = ack_take;
      IT_EXTERN: slot_clr[3] = ack_take;
      default:   slot_clr = '0;
    endcase
  end

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_take && sel_type == IT_REG) begin
      irr_d[irr_top] = 1'b0;
    end
    if (eoi && isr_any) begin
      isr_d[isr_top] = 1'b0;
    end
    if (ack_take && sel_type == IT_REG) begin
      isr_d[irr_top] = 1'b1;
    end
    if (req_regular && !irr_q[req_vector]) begin
      irr_d[req_vector] = 1'b1;
      tmr_d[req_vector] = req_level;
    end
  end

  assign state_en = req_regular || ack_take || eoi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else if (state_en) begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end

  AST_EXT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_type == IT_EXTERN || irq_type == IT_REG) |-> int_enable); // R5
  AST_REG_ABOVE_TPR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_type == IT_REG) |-> (irq_vector[VW-1 -: CLS_W] > task_prio[VW-1 -: CLS_W])); // R6
  AST_ACK_MOVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_type == IT_REG && !eoi) |=> (isr_q[$past(irq_vector)] && !irr_q[$past(irq_vector)])); // R8
  AST_UNMASK_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_pend[2:0]) |-> irq_pending); // R4
  AST_ONE_SLOT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_clr)); // R9
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_level, int_enable, ack, eoi;
  logic [7:0] req_vector, task_prio;
  logic [2:0] req_mode;
  logic       irq_pending, irq_level;
  logic [7:0] irq_vector;
  logic [2:0] irq_type;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_mode(req_mode), .req_level(req_level), .task_prio(task_prio),
    .int_enable(int_enable), .ack(ack), .eoi(eoi), .irq_pending(irq_pending),
    .irq_vector(irq_vector), .irq_type(irq_type), .irq_level(irq_level));

  task automatic chk(input string req, input logic p, input logic [2:0] t,
                     input logic [7:0] v, input logic l);
    n_chk++;
    if (irq_pending !== p || irq_type !== t || (p && irq_vector !== v) || irq_level !== l) begin
      n_err++;
      $display("FAIL %s: got pend=%0b type=%0d vec=%02h lvl=%0b, exp pend=%0b type=%0d vec=%02h lvl=%0b",
               req, irq_pending, irq_type, irq_vector, irq_level, p, t, v, l);
    end
  endtask

  task automatic cyc(input logic rv, input logic [7:0] v, input logic [2:0] m,
                     input logic lv, input logic a, input logic e);
    req_valid = rv; req_vector = v; req_mode = m; req_level = lv; ack = a; eoi = e;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; ack = 0; eoi = 0;
  endtask

  task automatic send(input logic [7:0] v, input logic [2:0] m, input logic lv);
    cyc(1, v, m, lv, 0, 0);
  endtask

  task automatic do_ack();
    cyc(0, 0, 0, 0, 1, 0);
  endtask

  task automatic do_eoi();
    cyc(0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_regular();
    send(8'h45, 3'd0, 1'b1);
    chk("R1", 1, 3'd5, 8'h45, 1);
    int_enable = 0; #1;
    chk("R5", 0, 3'd0, 8'h00, 0);
    int_enable = 1; task_prio = 8'h40; #1;
    chk("R6 equal class", 0, 3'd0, 8'h00, 0);
    task_prio = 8'h3F; #1;
    chk("R6 lower class", 1, 3'd5, 8'h45, 1);
    task_prio = 8'h00;
    send(8'h45, 3'd1, 1'b0);
    chk("R1 repeat keeps trigger", 1, 3'd5, 8'h45, 1);
  endtask

  task automatic t_inservice();
    do_ack();
    chk("R8 ack empties request", 0, 3'd0, 8'h00, 0);
    send(8'h42, 3'd0, 1'b0);
    chk("R6 below in-service", 0, 3'd0, 8'h00, 0);
    send(8'h60, 3'd1, 1'b0);
    chk("R6 above in-service", 1, 3'd5, 8'h60, 0);
    do_ack();
    chk("R8 second ack", 0, 3'd0, 8'h00, 0);
    do_eoi();
    chk("R10 first eoi", 0, 3'd0, 8'h00, 0);
    do_eoi();
    chk("R10 second eoi", 1, 3'd5, 8'h42, 0);
    do_ack();
    do_eoi();
    chk("R9 ack empty no effect", 0, 3'd0, 8'h00, 0);
    do_ack();
    chk("R9 idle ack", 0, 3'd0, 8'h00, 0);
  endtask

  task automatic t_order();
    send(8'h90, 3'd0, 1'b1);
    send(8'h33, 3'd7, 1'b0);
    send(8'h44, 3'd5, 1'b0);
    send(8'h22, 3'd4, 1'b0);
    send(8'h11, 3'd2, 1'b0);
    chk("R7 sys-mgmt first", 1, 3'd1, 8'h11, 0);
    send(8'h77, 3'd2, 1'b0);
    chk("R2 ignored while pending", 1, 3'd1, 8'h11, 0);
    do_ack();
    chk("R7 non-maskable next", 1, 3'd2, 8'h22, 0);
    do_ack();
    int_enable = 0; #1;
    chk("R4 init while masked", 1, 3'd3, 8'h44, 0);
    do_ack();
    chk("R5 external masked", 0, 3'd0, 8'h00, 0);
    int_enable = 1; #1;
    chk("R7 external", 1, 3'd4, 8'h33, 0);
    do_ack();
    chk("R9 regular remains", 1, 3'd5, 8'h90, 1);
  endtask

  task automatic t_overlap();
    cyc(1, 8'hA0, 3'd0, 1'b0, 1, 0);
    chk("R11 ack plus higher request", 1, 3'd5, 8'hA0, 0);
    do_ack();
    send(8'h22, 3'd4, 1'b0);
    chk("R2 nmask", 1, 3'd2, 8'h22, 0);
    cyc(1, 8'h55, 3'd4, 1'b0, 1, 0);
    chk("R11 same-class request dropped", 0, 3'd0, 8'h00, 0);
    send(8'h66, 3'd4, 1'b0);
    chk("R2 fresh capture", 1, 3'd2, 8'h66, 0);
    do_ack();
    send(8'hF0, 3'd3, 1'b0);
    send(8'hF1, 3'd6, 1'b1);
    chk("R3 reserved dropped", 0, 3'd0, 8'h00, 0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_vector = 0; req_mode = 0; req_level = 0;
    task_prio = 0; int_enable = 1; ack = 0; eoi = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset", 0, 3'd0, 8'h00, 0);
    rst_n = 1;
    @(negedge clk);
    t_regular();
    t_inservice();
    t_order();
    t_overlap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule